// File: doc/BRIEF.md
# Serial SRAM Slave

This block models a byte-organised static memory that sits behind a four-wire serial port and answers as the slave of an SPI bus in clock mode 0. The controller pulls chip select low, shifts in an 8-bit command and a 16-bit start address, and then moves data bytes into or out of the internal array. Each transaction ends when chip select returns high, and that abandons any transfer still in flight.

How consecutive bytes of one transaction are addressed depends on a static mode input. In the single-byte mode exactly one byte moves. In the page mode the address steps through one 32-byte page and wraps to the start of that page. In the burst mode the address steps through the whole array and wraps from the last location to zero. The serial output is driven only while read data is flowing. At all other times it is released to high impedance, and a separate enable pin reports when it is driven.

The pins `csN`, `sck` and `si` are sampled with the block clock, so that clock must run several times faster than the serial clock. The array holds 2^ADDR_W bytes. ADDR_W = 15 gives the full 32K-byte part. Address bits above ADDR_W are ignored.

Top module: `serial_sram_slave`

## Requirements
- R1: While `csN` is high, no access is in progress and `soOe` is low. Raising `csN` at any point aborts the current transfer, and the next falling edge of `csN` starts a new command.
- R2: The first 8 bits after `csN` falls form the command, sampled on rising `sck` edges, MSB first. Command 0x03 selects read and 0x02 selects write.
- R3: The next 16 bits form the start address, MSB first. Only the low ADDR_W bits are used. Bit 15 and every other bit above ADDR_W have no effect.
- R4: For a read, the MSB of the first data byte is driven on the falling `sck` edge after the 24th rising edge. Each following falling edge presents the next bit, MSB first.
- R5: `soOe` stays low (SO high impedance) during the command and address phases and for the whole of a write transaction.
- R6: With `mode` = 2'b01 (page), each byte after the first uses the next address within the same 32-byte page (page = address bits above bit 4). After word 31 the address returns to word 0 of that page, for both reads and writes.
- R7: With `mode` = 2'b10 (burst), each byte after the first uses the next array address. After the highest address the next one is 0.
- R8: A written byte replaces the stored byte at its address only once all 8 of its bits have been received. A byte cut short by `csN` rising leaves the array unchanged.
- R9: With `mode` = 2'b00 or 2'b11 (single byte), one byte is transferred. After a read byte, `soOe` falls on the next falling `sck` edge. Further write bytes do not change the array.
- R10: Any command other than 0x02 or 0x03 is ignored until `csN` rises. `soOe` stays low and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Sequential access mode: 00/11 single byte, 01 page, 10 burst |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the bus controller |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, high impedance when not driven |
| soOe | output | 1 | High while `so` is driven |

## Verification
The hardest case to reach from the pins is the wrap from the top of the array back to zero in burst mode. A burst has to cross every location in the array without chip select rising. The bench builds the block with an 8-bit array address, writes one continuous burst that starts part-way through the array and runs through all 256 locations, and then reads a burst of 258 bytes that passes the top address. Every byte is compared with a model that is filled by modular arithmetic. Cut-off bytes of every length from 1 to 7 bits are covered the same way. Each is followed by a read that shows the target byte unchanged.

// File: rtl/serial_sram_pkg.sv
package serial_sram_pkg;

  localparam int OP_BITS   = 8;
  localparam int ADDR_BITS = 16;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  localparam logic [1:0] MODE_WORD  = 2'b00;
  localparam logic [1:0] MODE_PAGE  = 2'b01;
  localparam logic [1:0] MODE_BURST = 2'b10;

  typedef struct packed {
    logic shiftEn;   // shift siQ into the receive register
    logic loadAddr;  // capture the start address
    logic loadOut;   // fetch array byte into the transmit register
    logic shiftOut;  // present next transmit bit
    logic memWrite;  // commit received byte
    logic advAddr;   // step the address pointer
    logic oeSet;     // start driving SO
    logic oeClr;     // release SO
  } dp_strobe_t;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_READ,
    ST_WRITE,
    ST_DONE,
    ST_IGNORE
  } seq_state_e;

endpackage

// File: rtl/serial_sram_ctrl.sv
module serial_sram_ctrl
  import serial_sram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       csIdle,
  input  logic [7:0] rxOp,
  output dp_strobe_t strb
);

  localparam int HDR_BITS = OP_BITS + ADDR_BITS;
  localparam int CNT_W    = $clog2(HDR_BITS);
  localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(OP_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] hdrCnt;
  logic [2:0]       bitCnt;
  logic             loadPend;
  logic             isRead;

  logic wordMode, opDone, hdrDone, byteDone;
  assign wordMode = (mode != MODE_PAGE) && (mode != MODE_BURST);
  assign opDone   = (hdrCnt == OP_LAST);
  assign hdrDone  = (hdrCnt == HDR_LAST);
  assign byteDone = (bitCnt == 3'd7);

  always_comb begin
    strb = '0;
    if (csIdle) begin
      strb.oeClr = 1'b1;
    end else begin
      case (state)
        ST_CMD: strb.shiftEn = sckRise;
        ST_ADDR: begin
          strb.shiftEn  = sckRise;
          strb.loadAddr = sckRise && hdrDone;
        end
        ST_READ: begin
          strb.loadOut  = sckFall && loadPend;
          strb.oeSet    = sckFall && loadPend;
          strb.advAddr  = sckFall && loadPend;
          strb.shiftOut = sckFall && !loadPend;
        end
        ST_WRITE: begin
          strb.shiftEn  = sckRise;
          strb.memWrite = sckRise && byteDone;
          strb.advAddr  = sckRise && byteDone;
        end
        ST_DONE: strb.oeClr = sckFall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      hdrCnt   <= '0;
      bitCnt   <= '0;
      loadPend <= 1'b0;
      isRead   <= 1'b0;
    end else if (csIdle) begin
      state    <= ST_CMD;
      hdrCnt   <= '0;
      bitCnt   <= '0;
      loadPend <= 1'b0;
      isRead   <= 1'b0;
    end else begin
      if (sckRise) begin
        case (state)
          ST_CMD: begin
            hdrCnt <= hdrCnt + CNT_W'(1);
            if (opDone) begin
              if (rxOp == OP_READ) begin
                state  <= ST_ADDR;
                isRead <= 1'b1;
              end else if (rxOp == OP_WRITE) begin
                state  <= ST_ADDR;
                isRead <= 1'b0;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR: begin
            hdrCnt <= hdrCnt + CNT_W'(1);
            if (hdrDone) begin
              state    <= isRead ? ST_READ : ST_WRITE;
              bitCnt   <= '0;
              loadPend <= isRead;
            end
          end
          ST_READ: begin
            bitCnt <= bitCnt + 3'd1;
            if (byteDone) begin
              if (wordMode) state <= ST_DONE;
              else          loadPend <= 1'b1;
            end
          end
          ST_WRITE: begin
            bitCnt <= bitCnt + 3'd1;
            if (byteDone && wordMode) state <= ST_DONE;
          end
          default: ;
        endcase
      end
      if (sckFall && state == ST_READ) loadPend <= 1'b0;
    end
  end

  AST_ONE_DATA_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadOut, strb.shiftOut, strb.memWrite, strb.loadAddr})); // R2
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> (!strb.memWrite && !strb.oeSet)); // R10
  AST_SINGLE_BYTE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |-> (!strb.memWrite && !strb.loadOut)); // R9

endmodule

// File: rtl/serial_sram_dp.sv
module serial_sram_dp
  import serial_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  dp_strobe_t strb,
  output logic       sckRise,
  output logic       sckFall,
  output logic       csIdle,
  output logic [7:0] rxOp,
  output logic       so,
  output logic       soOe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int RX_W  = (ADDR_W > OP_BITS) ? ADDR_W : OP_BITS;

  logic csQ, sckQ, sckP, siQ;
  logic [RX_W-2:0]   shReg;
  logic [RX_W-1:0]   rxWord;
  logic [ADDR_W-1:0] addr, nextAddr;
  logic [7:0]        outReg;
  logic              oe;
  logic [7:0]        mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ  <= 1'b1;
      sckQ <= 1'b0;
      sckP <= 1'b0;
      siQ  <= 1'b0;
    end else begin
      csQ  <= csN;
      sckQ <= sck;
      sckP <= sckQ;
      siQ  <= si;
    end
  end

  assign sckRise = sckQ && !sckP;
  assign sckFall = !sckQ && sckP;
  assign csIdle  = csQ;
  assign rxWord  = {shReg, siQ};
  assign rxOp    = rxWord[7:0];

  generate
    if (PAGE_W < ADDR_W) begin : g_paged
      always_comb begin
        if (mode == MODE_PAGE)
          nextAddr = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
        else
          nextAddr = addr + ADDR_W'(1);
      end
      AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
        (strb.advAddr && mode == MODE_PAGE) |=>
          (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]))); // R6
    end else begin : g_flat
      always_comb nextAddr = addr + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      addr   <= '0;
      outReg <= '0;
      oe     <= 1'b0;
    end else begin
      if (strb.shiftEn)       shReg <= rxWord[RX_W-2:0];
      if (strb.loadAddr)      addr  <= rxWord[ADDR_W-1:0];
      else if (strb.advAddr)  addr  <= nextAddr;
      if (strb.loadOut)       outReg <= mem[addr];
      else if (strb.shiftOut) outReg <= {outReg[6:0], 1'b0};
      if (strb.oeClr)         oe <= 1'b0;
      else if (strb.oeSet)    oe <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.memWrite) mem[addr] <= rxWord[7:0];
  end

  assign so   = oe ? outReg[7] : 1'bz;
  assign soOe = oe;

  AST_CS_RELEASES_SO: assert property (@(posedge clk) disable iff (!rstN)
    csQ |=> !oe); // R1
  AST_WRITE_HIGHZ: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWrite |-> !oe); // R5
  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advAddr && mode == MODE_BURST && addr == '1) |=> (addr == '0)); // R7

endmodule

// File: rtl/serial_sram_slave.sv
module serial_sram_slave
  import serial_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  output logic       so,
  output logic       soOe
);

  dp_strobe_t strb;
  logic       sckRise, sckFall, csIdle;
  logic [7:0] rxOp;

  serial_sram_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mode    (mode),
    .sckRise (sckRise),
    .sckFall (sckFall),
    .csIdle  (csIdle),
    .rxOp    (rxOp),
    .strb    (strb)
  );

  serial_sram_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .mode    (mode),
    .csN     (csN),
    .sck     (sck),
    .si      (si),
    .strb    (strb),
    .sckRise (sckRise),
    .sckFall (sckFall),
    .csIdle  (csIdle),
    .rxOp    (rxOp),
    .so      (so),
    .soOe    (soOe)
  );

endmodule

// File: tb/serial_sram_slave_bench.sv
`timescale 1ns/1ps
module serial_sram_slave_bench;

  localparam int AW   = 8;
  localparam int PW   = 5;
  localparam int SZ   = 1 << AW;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'b10;
  logic       csN = 1'b1;
  logic       sck = 1'b0;
  logic       si = 1'b0;
  wire        so;
  wire        soOe;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [SZ];

  always #10 clk = ~clk;

  serial_sram_slave #(.ADDR_W(AW), .PAGE_W(PW)) u_serial_sram_slave (
    .clk(clk), .rstN(rstN), .mode(mode), .csN(csN),
    .sck(sck), .si(si), .so(so), .soOe(soOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic spiBit(input logic b, output logic rb, output logic ob);
    si = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    rb = so;
    ob = soOe;
    sck = 1'b0;
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx, output int oeN);
    rx = '0;
    oeN = 0;
    for (int k = 7; k >= 0; k--) begin
      logic rb, ob;
      spiBit(tx[k], rb, ob);
      rx[k] = rb;
      oeN += int'(ob);
    end
  endtask

  task automatic beginTx(input logic [7:0] op, input logic [15:0] a, output int hdrOe);
    logic [7:0] rx;
    int o;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    hdrOe = 0;
    xferByte(op, rx, o);      hdrOe += o;
    xferByte(a[15:8], rx, o); hdrOe += o;
    xferByte(a[7:0], rx, o);  hdrOe += o;
  endtask

  task automatic endTx();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic readOne(input logic [1:0] m, input int a, output logic [7:0] rx);
    int h, o;
    mode = m;
    beginTx(8'h03, 16'(a), h);
    xferByte(8'h00, rx, o);
    endTx();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int h, o, tot;
    logic [7:0] rx, d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(soOe == 1'b0, "R5", "reset oe", int'(soOe), 0);

    // R2 R3 R7: burst write across the whole array; upper address bits set
    mode = 2'b10;
    beginTx(8'h02, 16'hAB05, h);
    chk(h == 0, "R5", "write header oe", h, 0);
    tot = 0;
    for (int i = 0; i < SZ; i++) begin
      d = 8'((i * 37 + 11) & 8'hFF);
      xferByte(d, rx, o);
      tot += o;
      model[(5 + i) % SZ] = d;
    end
    endTx();
    chk(tot == 0, "R5", "write data oe", tot, 0);

    // R4 R7: burst read past the top address
    beginTx(8'h03, 16'hFF00, h);
    chk(h == 0, "R4", "read header oe", h, 0);
    for (int i = 0; i < SZ + 2; i++) begin
      xferByte(8'h00, rx, o);
      chk(rx == model[i % SZ], (i >= SZ) ? "R7" : "R4", "burst read byte", int'(rx), int'(model[i % SZ]));
      chk(o == 8, "R4", "read oe bits", o, 8);
    end
    endTx();

    // R6 R8: page write from word 3 of page 1, 34 bytes wrap and overwrite
    mode = 2'b01;
    beginTx(8'h02, 16'h0023, h);
    for (int i = 0; i < 34; i++) begin
      d = 8'(i) ^ 8'h5A;
      xferByte(d, rx, o);
      model[32 + ((3 + i) % 32)] = d;
    end
    endTx();
    readOne(2'b00, 16'h23, rx);
    chk(rx == (8'd32 ^ 8'h5A), "R8", "overwritten byte", int'(rx), int'(8'd32 ^ 8'h5A));
    readOne(2'b00, 16'h40, rx);
    chk(rx == model[64], "R6", "next page untouched", int'(rx), int'(model[64]));

    // R6: page read wraps from word 31 back to word 0
    mode = 2'b01;
    beginTx(8'h03, 16'h003E, h);
    for (int i = 0; i < 34; i++) begin
      xferByte(8'h00, rx, o);
      chk(rx == model[32 + ((30 + i) % 32)], "R6", "page read byte", int'(rx),
          int'(model[32 + ((30 + i) % 32)]));
    end
    endTx();

    // R9: single byte mode, both encodings
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < 4; j++) begin
        int a;
        logic [7:0] d1;
        a = 8'h90 + j * 9 + m * 3;
        d1 = 8'hC0 + 8'(j) + 8'(m * 16);
        mode = (m == 0) ? 2'b00 : 2'b11;
        beginTx(8'h02, 16'(a), h);
        xferByte(d1, rx, o);
        xferByte(~d1, rx, o);
        endTx();
        model[a] = d1;
        mode = (m == 0) ? 2'b00 : 2'b11;
        beginTx(8'h03, 16'(a), h);
        xferByte(8'h00, rx, o);
        chk(rx == d1, "R9", "single byte read", int'(rx), int'(d1));
        xferByte(8'h00, rx, o);
        chk(o == 0, "R9", "oe after single byte", o, 0);
        endTx();
        readOne(2'b10, a + 1, rx);
        chk(rx == model[a + 1], "R9", "second write byte ignored", int'(rx), int'(model[a + 1]));
      end
    end

    // R8: bytes cut short by chip select are discarded
    for (int nb = 1; nb < 8; nb++) begin
      int a;
      logic [7:0] nd;
      a = 8'h50 + nb;
      nd = ~model[a];
      mode = 2'b10;
      beginTx(8'h02, 16'(a), h);
      for (int k = 7; k > 7 - nb; k--) begin
        logic rb, ob;
        spiBit(nd[k], rb, ob);
      end
      endTx();
      readOne(2'b10, a, rx);
      chk(rx == model[a], "R8", "partial byte discarded", int'(rx), int'(model[a]));
    end

    // R10: unknown commands
    for (int u = 0; u < 6; u++) begin
      logic [7:0] op;
      case (u)
        0: op = 8'h00;
        1: op = 8'h01;
        2: op = 8'h04;
        3: op = 8'h05;
        4: op = 8'h83;
        default: op = 8'h82;
      endcase
      mode = 2'b10;
      beginTx(op, 16'h0060, h);
      xferByte(8'hEE, rx, o);
      xferByte(8'hEE, rx, tot);
      endTx();
      chk(h + o + tot == 0, "R10", "oe on unknown command", h + o + tot, 0);
      readOne(2'b10, 16'h60, rx);
      chk(rx == model[8'h60], "R10", "array unchanged", int'(rx), int'(model[8'h60]));
    end

    // R1: chip select rising in the middle of a read
    mode = 2'b10;
    beginTx(8'h03, 16'h0070, h);
    xferByte(8'h00, rx, o);
    chk(rx == model[8'h70], "R1", "read before abort", int'(rx), int'(model[8'h70]));
    for (int k = 0; k < 4; k++) begin
      logic rb, ob;
      spiBit(1'b0, rb, ob);
    end
    chk(soOe == 1'b1, "R1", "oe mid byte", int'(soOe), 1);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    chk(soOe == 1'b0, "R1", "oe after abort", int'(soOe), 0);
    repeat (3 * HALF) @(negedge clk);
    readOne(2'b00, 16'h71, rx);
    chk(rx == model[8'h71], "R1", "fresh command after abort", int'(rx), int'(model[8'h71]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule